// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of one eight-input interrupt controller. A one-bit address and an eight-bit data bus, driven with separate write and read strobes, carry setup words and run-time commands. A write to address 0 is decoded by its data bits as one of three things: the start of setup, a control word, or a command word. A write to address 1 means different things at different points in the setup sequence. Once setup is over, it loads the mask.

The decoder holds the mask, the vector base and the mode bits. It turns command words into single-cycle end-of-service and priority-rotation pulses for the priority core that sits beside it. Reads return the request, in-service or mask value, or a poll result that the core supplies. Read data is registered and valid in the cycle after the read strobe.

Top module: `intc_cmd_decoder`

## Requirements
- R1: After reset, the mask, vector base, all mode bits, poll-pending and read data are zero, the read select chooses requests, and no pulse output is high.
- R2: A write to address 0 with data bit 4 set starts setup. In the next cycle the mask, special mask and read select are cleared, and lvlClear and rotLoad pulse with rotValue 0. Nested mode and auto-EOI are cleared when data bit 0 is 0 and kept when it is 1.
- R3: The first address-1 write after setup starts stores vecBase = data AND 0xF8.
- R4: The second address-1 write of setup is consumed without effect. It leads to the mode step if the setup word had bit 0 set, and otherwise back to normal operation.
- R5: The mode-step write sets nestedMode from data bit 4 and autoEoi from data bit 1, then returns to normal operation.
- R6: In normal operation a write to address 1 loads the mask, which is visible in the next cycle.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 set makes poll pending. Bit 1 set loads the read select from bit 0 (1 = in-service). Bit 6 set loads specialMask from bit 5.
- R8: For an address-0 write with bits 4 and 3 clear, the command is bits 7:5. Command 0 or 4 loads rotOnAutoEoi from bit 7. Command 2 changes no output.
- R9: Commands 1, 5, 3 and 7 give a one-cycle eoiValid in the next cycle. eoiSpecific is 1 for 3 and 7, eoiRotate is 1 for 5 and 7, and eoiIndex carries data bits 2:0.
- R10: Command 6 gives a one-cycle rotLoad with rotValue = (data bits 2:0 + 1) mod 8.
- R11: An accepted read with no poll pending gives rdData in the next cycle. Address 1 returns the mask. Address 0 returns svcVec if the read select is 1 and reqVec otherwise. rdData holds between accepted reads.
- R12: An accepted read while poll is pending returns pollCode, pulses pollTake and clears poll-pending.
- R13: Setup-word bits 1 and 3 are ignored. The sequence still consumes the base word and the cascade word.
- R14: When wrEn and rdEn are high in the same cycle, only the write is performed. rdData holds and a pending poll stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| reqVec | input | 8 | Request vector from the core, for readback |
| svcVec | input | 8 | In-service vector from the core, for readback |
| pollCode | input | 8 | Poll result from the core |
| maskOut | output | 8 | Mask register |
| vecBase | output | 8 | Vector base, low three bits zero |
| nestedMode | output | 1 | Special fully nested mode |
| autoEoi | output | 1 | Automatic end-of-service mode |
| rotOnAutoEoi | output | 1 | Rotate on automatic end-of-service |
| specialMask | output | 1 | Special mask mode |
| readInService | output | 1 | Read select: 1 = in-service, 0 = request |
| pollPending | output | 1 | Poll requested, not yet read |
| pollTake | output | 1 | One-cycle pulse: the poll result was read |
| lvlClear | output | 1 | One-cycle pulse: clear the core's last-level bits |
| eoiValid | output | 1 | One-cycle end-of-service pulse |
| eoiSpecific | output | 1 | End-of-service names an index |
| eoiRotate | output | 1 | End-of-service rotates priority |
| eoiIndex | output | 3 | End-of-service index |
| rotLoad | output | 1 | One-cycle pulse: load the rotation offset |
| rotValue | output | 3 | Rotation offset to load |

## Verification
A write and a read can be strobed in the same cycle. The write must then win, and the read must leave no trace. The bench drives both strobes together twice. The first time, the address-1 write loads the mask while rdData must keep its earlier value. The second time, the write is a control word while a poll is pending, and the following plain read must still return the poll code. The behavioural model in the bench applies the same write-first rule and is compared with every output on every clock.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CMD_W  = 3;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_BASE    = 2'd1,
    ST_CASCADE = 2'd2,
    ST_MODE    = 2'd3
  } initStep_t;

  typedef struct packed {
    logic              initStart;
    logic              fourthWord;
    logic              baseLoad;
    logic              modeLoad;
    logic              maskLoad;
    logic              pollSet;
    logic              selLoad;
    logic              smLoad;
    logic              raeoiLoad;
    logic              readGo;
    logic              readAddr;
    logic [DATA_W-1:0] data;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_cmd_ctrl.sv
module intc_cmd_ctrl
  import intc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       strobe,
  output logic              lvlClear,
  output logic              eoiValid,
  output logic              eoiSpecific,
  output logic              eoiRotate,
  output logic [IDX_W-1:0]  eoiIndex,
  output logic              rotLoad,
  output logic [IDX_W-1:0]  rotValue
);
  initStep_t        step, stepNext;
  logic             fourthQ;
  logic [CMD_W-1:0] cmdField;
  logic             isInit, isCtl, isCmd, dataWr, isEoi, isRotSet;

  assign cmdField = wrData[DATA_W-1 -: CMD_W];
  assign isInit   = wrEn && !addr && wrData[4];
  assign isCtl    = wrEn && !addr && !wrData[4] && wrData[3];
  assign isCmd    = wrEn && !addr && !wrData[4] && !wrData[3];
  assign dataWr   = wrEn && addr;
  assign isEoi    = isCmd && cmdField[0];
  assign isRotSet = isCmd && (cmdField == 3'd6);

  always_comb begin
    strobe            = '0;
    strobe.initStart  = isInit;
    strobe.fourthWord = wrData[0];
    strobe.baseLoad   = dataWr && (step == ST_BASE);
    strobe.modeLoad   = dataWr && (step == ST_MODE);
    strobe.maskLoad   = dataWr && (step == ST_NORMAL);
    strobe.pollSet    = isCtl && wrData[2];
    strobe.selLoad    = isCtl && wrData[1];
    strobe.smLoad     = isCtl && wrData[6];
    strobe.raeoiLoad  = isCmd && (cmdField[1:0] == 2'b00);
    strobe.readGo     = rdEn && !wrEn;
    strobe.readAddr   = addr;
    strobe.data       = wrData;
  end

  always_comb begin
    stepNext = step;
    if (isInit) begin
      stepNext = ST_BASE;
    end else if (dataWr) begin
      case (step)
        ST_BASE:    stepNext = ST_CASCADE;
        ST_CASCADE: stepNext = fourthQ ? ST_MODE : ST_NORMAL;
        ST_MODE:    stepNext = ST_NORMAL;
        default:    stepNext = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step        <= ST_NORMAL;
      fourthQ     <= 1'b0;
      lvlClear    <= 1'b0;
      eoiValid    <= 1'b0;
      eoiSpecific <= 1'b0;
      eoiRotate   <= 1'b0;
      eoiIndex    <= '0;
      rotLoad     <= 1'b0;
      rotValue    <= '0;
    end else begin
      step        <= stepNext;
      if (isInit) fourthQ <= wrData[0];
      lvlClear    <= isInit;
      eoiValid    <= isEoi;
      eoiSpecific <= isEoi && cmdField[1];
      eoiRotate   <= isEoi && cmdField[2];
      eoiIndex    <= isEoi ? wrData[IDX_W-1:0] : '0;
      rotLoad     <= isInit || isRotSet;
      rotValue    <= isRotSet ? IDX_W'(wrData[IDX_W-1:0] + 1'b1) : '0;
    end
  end

  // R2
  init_rot_chk: assert property (@(posedge clk) disable iff (!rstN)
    lvlClear |-> (rotLoad && rotValue == '0));
  // R9
  eoi_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid |-> $past(wrEn && !addr && wrData[4:3] == 2'b00));
  // R10
  rot_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[7:3] == 5'b11000) |=>
      (rotLoad && rotValue == IDX_W'($past(wrData[IDX_W-1:0]) + 1'b1)));
  // R4
  step_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_MODE && dataWr && !isInit) |=> step == ST_NORMAL);
endmodule

// File: rtl/intc_cmd_regs.sv
module intc_cmd_regs
  import intc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqVec,
  input  logic [DATA_W-1:0] svcVec,
  input  logic [DATA_W-1:0] pollCode,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] vecBase,
  output logic              nestedMode,
  output logic              autoEoi,
  output logic              rotOnAutoEoi,
  output logic              specialMask,
  output logic              readInService,
  output logic              pollPending,
  output logic              pollTake,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'((1 << IDX_W) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ         <= '0;
      vecBase       <= '0;
      nestedMode    <= 1'b0;
      autoEoi       <= 1'b0;
      rotOnAutoEoi  <= 1'b0;
      specialMask   <= 1'b0;
      readInService <= 1'b0;
      pollPending   <= 1'b0;
      pollTake      <= 1'b0;
      rdData        <= '0;
    end else begin
      pollTake <= 1'b0;
      if (strobe.initStart) begin
        maskQ         <= '0;
        specialMask   <= 1'b0;
        readInService <= 1'b0;
        if (!strobe.fourthWord) begin
          nestedMode <= 1'b0;
          autoEoi    <= 1'b0;
        end
      end
      if (strobe.baseLoad) vecBase <= strobe.data & BASE_KEEP;
      if (strobe.modeLoad) begin
        nestedMode <= strobe.data[4];
        autoEoi    <= strobe.data[1];
      end
      if (strobe.maskLoad)  maskQ         <= strobe.data;
      if (strobe.pollSet)   pollPending   <= 1'b1;
      if (strobe.selLoad)   readInService <= strobe.data[0];
      if (strobe.smLoad)    specialMask   <= strobe.data[5];
      if (strobe.raeoiLoad) rotOnAutoEoi  <= strobe.data[7];
      if (strobe.readGo) begin
        if (pollPending) begin
          rdData      <= pollCode;
          pollPending <= 1'b0;
          pollTake    <= 1'b1;
        end else if (strobe.readAddr) begin
          rdData <= maskQ;
        end else begin
          rdData <= readInService ? svcVec : reqVec;
        end
      end
    end
  end

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.readGo |=> $stable(rdData));
  // R12
  poll_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollTake |-> !pollPending);
  // R2
  init_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initStart |=> (maskQ == '0 && !specialMask && !readInService));
  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskLoad |=> maskQ == $past(strobe.data));
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
  import intc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [7:0]       reqVec,
  input  logic [7:0]       svcVec,
  input  logic [7:0]       pollCode,
  output logic [7:0]       maskOut,
  output logic [7:0]       vecBase,
  output logic             nestedMode,
  output logic             autoEoi,
  output logic             rotOnAutoEoi,
  output logic             specialMask,
  output logic             readInService,
  output logic             pollPending,
  output logic             pollTake,
  output logic             lvlClear,
  output logic             eoiValid,
  output logic             eoiSpecific,
  output logic             eoiRotate,
  output logic [2:0]       eoiIndex,
  output logic             rotLoad,
  output logic [2:0]       rotValue
);
  ctrlStrobe_t strobe;

  intc_cmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strobe(strobe), .lvlClear(lvlClear),
    .eoiValid(eoiValid), .eoiSpecific(eoiSpecific), .eoiRotate(eoiRotate),
    .eoiIndex(eoiIndex), .rotLoad(rotLoad), .rotValue(rotValue)
  );

  intc_cmd_regs regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVec(reqVec),
    .svcVec(svcVec), .pollCode(pollCode), .maskQ(maskOut),
    .vecBase(vecBase), .nestedMode(nestedMode), .autoEoi(autoEoi),
    .rotOnAutoEoi(rotOnAutoEoi), .specialMask(specialMask),
    .readInService(readInService), .pollPending(pollPending),
    .pollTake(pollTake), .rdData(rdData)
  );
endmodule

// File: tb/intc_cmd_decoder_tb.sv
module intc_cmd_decoder_tb_top;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0, reqVec = '0, svcVec = '0, pollCode = '0;
  logic [7:0] rdData, maskOut, vecBase;
  logic nestedMode, autoEoi, rotOnAutoEoi, specialMask, readInService;
  logic pollPending, pollTake, lvlClear, eoiValid, eoiSpecific, eoiRotate, rotLoad;
  logic [2:0] eoiIndex, rotValue;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  intc_cmd_decoder dut_i (.*);

  // behavioural reference state
  logic [7:0] mMask, mBase, mRd;
  logic mNest, mAeoi, mRae, mSm, mSel, mPoll, mTake, mLvl, mEoiV, mEoiS, mEoiR, mRotL, mFour;
  logic [2:0] mEoiI, mRotV;
  int mStep;

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mBase = 0; mRd = 0; mNest = 0; mAeoi = 0; mRae = 0; mSm = 0;
      mSel = 0; mPoll = 0; mTake = 0; mLvl = 0; mEoiV = 0; mEoiS = 0; mEoiR = 0;
      mRotL = 0; mFour = 0; mEoiI = 0; mRotV = 0; mStep = 0;
    end else begin
      int c;
      mTake = 0; mLvl = 0; mEoiV = 0; mEoiS = 0; mEoiR = 0; mEoiI = 0; mRotL = 0; mRotV = 0;
      c = int'(wrData[7:5]);
      if (wrEn) begin
        if (!addr) begin
          if (wrData[4]) begin
            mFour = wrData[0]; mMask = 0; mSm = 0; mSel = 0; mRotL = 1; mLvl = 1;
            if (!wrData[0]) begin mNest = 0; mAeoi = 0; end
            mStep = 1;
          end else if (wrData[3]) begin
            if (wrData[2]) mPoll = 1;
            if (wrData[1]) mSel = wrData[0];
            if (wrData[6]) mSm = wrData[5];
          end else begin
            if (c == 0 || c == 4) mRae = wrData[7];
            if (c == 1 || c == 3 || c == 5 || c == 7) begin
              mEoiV = 1; mEoiS = (c == 3 || c == 7); mEoiR = (c >= 5); mEoiI = wrData[2:0];
            end
            if (c == 6) begin mRotL = 1; mRotV = 3'((int'(wrData[2:0]) + 1) % 8); end
          end
        end else begin
          case (mStep)
            0: mMask = wrData;
            1: begin mBase = wrData & 8'hF8; mStep = 2; end
            2: mStep = mFour ? 3 : 0;
            default: begin mNest = wrData[4]; mAeoi = wrData[1]; mStep = 0; end
          endcase
        end
      end else if (rdEn) begin
        if (mPoll) begin mRd = pollCode; mPoll = 0; mTake = 1; end
        else mRd = addr ? mMask : (mSel ? svcVec : reqVec);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) if (rstN && !finished) begin
    chk("R6 maskOut model", maskOut, mMask);
    chk("R3 vecBase model", vecBase, mBase);
    chk("R5 modes model", {nestedMode, autoEoi}, {mNest, mAeoi});
    chk("R7 ctrl bits model", {specialMask, readInService, pollPending}, {mSm, mSel, mPoll});
    chk("R8 rotOnAutoEoi model", rotOnAutoEoi, mRae);
    chk("R11 rdData model", rdData, mRd);
    chk("R12 pollTake model", pollTake, mTake);
    chk("R9 eoi model", {eoiValid, eoiSpecific, eoiRotate, eoiIndex},
        {mEoiV, mEoiS, mEoiR, mEoiI});
    chk("R10 rot model", {rotLoad, rotValue, lvlClear}, {mRotL, mRotV, mLvl});
  end

  task automatic op(bit w, bit r, bit a, logic [7:0] d);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; rdEn = 0; addr = 0; wrData = 0;
  endtask
  task automatic wr(bit a, logic [7:0] d); op(1, 0, a, d); endtask
  task automatic rd(bit a); op(0, 1, a, 8'h00); endtask

  initial begin
    #1600000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", maskOut, 0); chk("R1 rdData", rdData, 0);
    chk("R1 pulses", {eoiValid, rotLoad, lvlClear, pollTake}, 0);
    // setup with mode step
    wr(0, 8'h11);
    chk("R2 lvlClear", {lvlClear, rotLoad, rotValue}, 5'b11000);
    wr(1, 8'h57); chk("R3 base", vecBase, 8'h50);
    wr(1, 8'h04); wr(1, 8'h12);
    chk("R5 modes", {nestedMode, autoEoi}, 2'b11);
    wr(1, 8'hA5); chk("R6 mask", maskOut, 8'hA5);
    rd(1); chk("R11 mask read", rdData, 8'hA5);
    // R2 with fourth word expected keeps modes
    wr(0, 8'h11); chk("R2 mask cleared", maskOut, 0);
    chk("R2 modes kept", {nestedMode, autoEoi}, 2'b11);
    wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h10);
    chk("R5 mode word", {nestedMode, autoEoi}, 2'b10);
    reqVec = 8'h3C; svcVec = 8'h81;
    rd(0); chk("R11 request read", rdData, 8'h3C);
    wr(0, 8'h0B); rd(0); chk("R7 in-service read", rdData, 8'h81);
    wr(0, 8'h68); chk("R7 special mask", specialMask, 1);
    // R12 poll
    pollCode = 8'h85;
    wr(0, 8'h0C); chk("R7 poll pending", pollPending, 1);
    rd(1); chk("R12 poll data", rdData, 8'h85); chk("R12 pollTake", pollTake, 1);
    rd(0); chk("R12 poll consumed", rdData, 8'h81);
    // R9 EOI variants
    wr(0, 8'h20); chk("R9 nonspecific", {eoiValid, eoiSpecific, eoiRotate}, 3'b100);
    wr(0, 8'hE6); chk("R9 specific rotate", {eoiValid, eoiSpecific, eoiRotate, eoiIndex}, 6'b111110);
    wr(0, 8'h63); chk("R9 specific", {eoiValid, eoiSpecific, eoiRotate, eoiIndex}, 6'b110011);
    wr(0, 8'hA0); chk("R9 rotate nonspecific", {eoiValid, eoiSpecific, eoiRotate}, 3'b101);
    // R10 offset set with wrap
    wr(0, 8'hC7); chk("R10 wrap", {rotLoad, rotValue}, 4'b1000);
    wr(0, 8'hC2); chk("R10 offset", {rotLoad, rotValue}, 4'b1011);
    // R8
    wr(0, 8'h80); chk("R8 rae set", rotOnAutoEoi, 1);
    wr(0, 8'h40); chk("R8 cmd2 no effect", {rotOnAutoEoi, eoiValid, rotLoad}, 3'b100);
    wr(0, 8'h00); chk("R8 rae clear", rotOnAutoEoi, 0);
    // R14 collisions
    op(1, 1, 1, 8'h33);
    chk("R14 write done", maskOut, 8'h33); chk("R14 read dropped", rdData, 8'h81);
    wr(0, 8'h0C); op(1, 1, 0, 8'h0A);
    chk("R14 poll kept", pollPending, 1);
    rd(1); chk("R14 poll after collision", rdData, 8'h85);
    // R13 ignored setup bits, no fourth word
    wr(0, 8'h1A);
    chk("R2 modes cleared", {nestedMode, autoEoi}, 2'b00);
    wr(1, 8'h0F); chk("R3 base mask", vecBase, 8'h08);
    wr(1, 8'hFF); chk("R13 cascade consumed", maskOut, 0);
    wr(1, 8'h3C); chk("R4 normal after cascade", maskOut, 8'h3C);
    rd(1); chk("R11 final mask read", rdData, 8'h3C);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule